// File: doc/BRIEF.md
# Packed Single-Precision Fraction Trimmer

This unit takes a vector of IEEE-754 single-precision lanes and, in every lane, strips away the integer part and the leading M fraction bits. What remains is the low-order residue. Each lane computes `x - round(x * 2^M) * 2^-M`. The count M and the rounding direction come from an 8-bit control byte. Because the rounding can go up or down, the residue may carry the opposite sign to the source.

A per-lane write mask chooses which lanes receive a new result. Lanes that are not written either keep a supplied previous value or are cleared, as selected by a zero-fill input. A single inexact indication is formed from the written lanes only, and one control bit can silence it.

The unit accepts one vector per cycle through a valid/ready handshake. It holds one result in a single output register.

Top module: `vec_frac_trim`

## Requirements
- R1: For a finite non-zero written lane, the result is `x - n * 2^-M`. M is the unsigned value of `ctrl_imm[7:4]`. n is `x * 2^M` rounded to an integer in the selected mode. A residue that does not fit in 24 significand bits is truncated toward zero in magnitude.
- R2: The mode is taken from `ctrl_imm[1:0]` when `ctrl_imm[2]` is 0, and from `rc_in` when it is 1. The mode codes are: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R3: A zero residue is returned as a zero that carries the sign of the source. This includes every case where `x * 2^M` is already an integer.
- R4: A lane is inexact when its residue lost non-zero bits to truncation. `inexact` is the OR of this condition over the written lanes.
- R5: When `ctrl_imm[3]` is 1, `inexact` is 0 regardless of the lanes.
- R6: A NaN source lane returns the same NaN with fraction bit 22 set.
- R7: An infinity of either sign returns +0. A zero source returns that same zero.
- R8: Subnormal sources are handled by their exact value, including directed rounding that yields a residue of magnitude just below `2^-M`.
- R9: A lane whose `wmask` bit is 0 returns `prev_dst` for that lane when `zero_fill` is 0, and returns 0 when `zero_fill` is 1. Such a lane never sets `inexact`.
- R10: `in_ready` is high exactly when the output register is empty or is being drained. While `out_valid` is high and `out_ready` is low, `dst` and `inexact` hold their values.
- R11: After reset, `out_valid`, `dst` and `inexact` are all 0.
- R12: Lane `i` occupies bits `[32*i+31 : 32*i]` of `src`, `prev_dst` and `dst`, and its mask bit is `wmask[i]`. The `LANES` parameter sets the vector to 4, 8 or 16 lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector is present |
| in_ready | output | 1 | Unit can take an input vector |
| src | input | 32*LANES | Source lanes |
| prev_dst | input | 32*LANES | Values kept by unwritten lanes in merge mode |
| ctrl_imm | input | 8 | Fraction count, inexact silence, mode source, mode |
| rc_in | input | 2 | External rounding mode |
| wmask | input | LANES | Per-lane write enable |
| zero_fill | input | 1 | Clear unwritten lanes instead of merging |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| dst | output | 32*LANES | Result lanes |
| inexact | output | 1 | Truncation loss in a written lane |

## Verification
The properties assume that the consumer obeys the handshake. The stall property only claims that data is held while `out_ready` is low. The silence and clear properties assume that the control inputs are sampled in the same cycle the vector is accepted. The stimulus changes `src` and the control inputs freely while `in_valid` is high but not yet accepted, so only the accepting cycle's values define a result. Random finite sources are drawn from exponents that keep every exact residue within double precision, so the bench's real-number model is exact. Subnormals and the other special encodings are mixed in at a fixed rate.

// File: rtl/vec_frac_trim.sv
module vec_frac_trim #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [32*LANES-1:0]   src,
  input  logic [32*LANES-1:0]   prev_dst,
  input  logic [7:0]            ctrl_imm,
  input  logic [1:0]            rc_in,
  input  logic [LANES-1:0]      wmask,
  input  logic                  zero_fill,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [32*LANES-1:0]   dst,
  output logic                  inexact
);
  localparam int VW = 32 * LANES;
  localparam int FW = 49;

  // returns {lane_inexact, result}
  function automatic logic [32:0] trim_lane(input logic [31:0] a, input logic [3:0] m,
                                            input logic [1:0] mode);
    logic          sgn, inc, half, below, lsb, lost;
    logic [7:0]    ex;
    logic [22:0]   fr;
    logic [FW-1:0] sig, msk, rem, hb, dmag;
    logic [23:0]   nsig;
    int            k, kc, lead, sh, bexp;
    logic [32:0]   res;
    sgn = a[31]; ex = a[30:23]; fr = a[22:0];
    res = {1'b0, sgn, 31'd0};
    if (ex == 8'hFF) begin
      res = (fr != 23'd0) ? {1'b0, a[31:23], 1'b1, fr[21:0]} : 33'd0;
    end else if (!(ex == 8'd0 && fr == 23'd0)) begin
      sig = {25'd0, ex != 8'd0, fr};
      k = (ex == 8'd0) ? 149 - int'(m) : 150 - int'(ex) - int'(m);
      if (k > 0) begin
        kc    = (k > 48) ? 48 : k;
        msk   = (49'd1 << kc) - 49'd1;
        rem   = sig & msk;
        hb    = 49'd1 << (kc - 1);
        half  = |(rem & hb);
        below = |(rem & (hb - 49'd1));
        lsb   = |((sig >> kc) & 49'd1);
        case (mode)
          2'b00:   inc = half && (below || lsb);
          2'b01:   inc = sgn && (rem != '0);
          2'b10:   inc = !sgn && (rem != '0);
          default: inc = 1'b0;
        endcase
        dmag = inc ? (msk + 49'd1 - rem) : rem;
        if (!inc && rem == '0) begin
          res = {1'b0, sgn, 31'd0};
        end else if (!inc && k >= 24) begin
          res = {1'b0, a};
        end else begin
          lead = 0;
          for (int i = 0; i < FW; i++) if (dmag[i]) lead = i;
          lost = 1'b0;
          if (lead >= 23) begin
            sh   = lead - 23;
            nsig = 24'(dmag >> sh);
            lost = |(dmag & ((49'd1 << sh) - 49'd1));
          end else begin
            nsig = 24'(dmag << (23 - lead));
          end
          bexp = lead - kc - int'(m) + 127;
          res  = {lost, sgn ^ inc, 8'(bexp), nsig[22:0]};
        end
      end
    end
    return res;
  endfunction

  logic [1:0]       mode;
  logic [VW-1:0]    nxt;
  logic [LANES-1:0] lane_flag;

  assign mode     = ctrl_imm[2] ? rc_in : ctrl_imm[1:0];
  assign in_ready = !out_valid || out_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [32:0] lr;
    assign lr = trim_lane(src[32*g +: 32], ctrl_imm[7:4], mode);
    assign nxt[32*g +: 32] = wmask[g] ? lr[31:0] : (zero_fill ? 32'd0 : prev_dst[32*g +: 32]);
    assign lane_flag[g] = wmask[g] & lr[32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      inexact   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      dst       <= nxt;
      inexact   <= !ctrl_imm[3] && (|lane_flag);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vec_frac_trim_chk.sv
module vec_frac_trim_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [7:0]          ctrl_imm,
  input logic [LANES-1:0]    wmask,
  input logic                zero_fill,
  input logic                out_valid,
  input logic                out_ready,
  input logic [32*LANES-1:0] dst,
  input logic                inexact
);
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dst) && $stable(inexact)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R10
  AST_QUIET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ctrl_imm[3] |=> !inexact); // R5
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && zero_fill && wmask == '0 |=> dst == '0 && !inexact); // R9
endmodule

bind vec_frac_trim vec_frac_trim_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ctrl_imm(ctrl_imm), .wmask(wmask), .zero_fill(zero_fill),
  .out_valid(out_valid), .out_ready(out_ready), .dst(dst), .inexact(inexact)
);

// File: tb/test_vec_frac_trim.sv
module test_vec_frac_trim;
  localparam int LANES = 4;
  localparam int VW = 32 * LANES;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, zero_fill, out_valid, out_ready, inexact;
  logic [VW-1:0] src, prev_dst, dst;
  logic [7:0] ctrl_imm;
  logic [1:0] rc_in;
  logic [LANES-1:0] wmask;

  int total = 0, bad = 0;

  vec_frac_trim #(.LANES(LANES)) i_vec_frac_trim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .prev_dst(prev_dst), .ctrl_imm(ctrl_imm), .rc_in(rc_in),
    .wmask(wmask), .zero_fill(zero_fill), .out_valid(out_valid),
    .out_ready(out_ready), .dst(dst), .inexact(inexact)
  );

  logic [VW-1:0]    q_src[$], q_prev[$];
  logic [7:0]       q_imm[$];
  logic [1:0]       q_rc[$];
  logic [LANES-1:0] q_mask[$];
  logic             q_zf[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic real pow2(input int n);
    real v = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) v = v * 2.0;
    else for (int i = 0; i < -n; i++) v = v * 0.5;
    return v;
  endfunction

  function automatic real to_real(input logic [31:0] a);
    real v;
    if (a[30:23] == 8'd0) v = real'(a[22:0]) * pow2(-149);
    else v = real'({1'b1, a[22:0]}) * pow2(int'(a[30:23]) - 150);
    return a[31] ? -v : v;
  endfunction

  // {flag, bits} from the requirements, using real arithmetic
  function automatic logic [32:0] ref_lane(input logic [31:0] a, input int m, input logic [1:0] md);
    real x, t, f, d, n, r, mag, fs, fl;
    int e;
    longint si;
    logic s;
    s = a[31];
    if (a[30:23] == 8'hFF) return (a[22:0] != 0) ? {1'b0, a | 32'h0040_0000} : 33'd0; // R6 R7
    if (a[30:0] == 31'd0) return {1'b0, a};
    x = to_real(a);
    t = x * pow2(m);
    f = $floor(t);
    case (md)
      2'b00: begin
        d = t - f;
        if (d > 0.5) n = f + 1.0;
        else if (d < 0.5) n = f;
        else n = ((f - 2.0 * $floor(f / 2.0)) == 0.0) ? f : f + 1.0;
      end
      2'b01: n = f;
      2'b10: n = $ceil(t);
      default: n = (t >= 0.0) ? f : $ceil(t);
    endcase
    if (a[30:23] == 8'd0) begin // R8
      if (n == 0.0) return {1'b0, a};
      return {1'b1, ~s, 8'(126 - m), 23'h7FFFFF};
    end
    r = x - n * pow2(-m);
    if (r == 0.0) return {1'b0, s, 31'd0}; // R3
    mag = (r < 0.0) ? -r : r;
    e = 0;
    while (mag >= 2.0) begin mag = mag / 2.0; e++; end
    while (mag < 1.0) begin mag = mag * 2.0; e--; end
    fs = mag * pow2(23);
    fl = $floor(fs);
    si = longint'(fl);
    return {fs != fl, r < 0.0, 8'(e + 127), si[22:0]};
  endfunction

  function automatic logic [31:0] gen_lane();
    int c = $urandom_range(0, 15);
    logic s = 1'($urandom_range(0, 1));
    logic [22:0] fr = 23'($urandom);
    case (c)
      0: return {s, 8'hFF, (fr == 0) ? 23'd5 : fr};
      1: return {s, 8'hFF, 23'd0};
      2: return {s, 31'd0};
      3: return {s, 8'd0, (fr == 0) ? 23'd1 : fr};
      default: return {s, 8'($urandom_range(100, 155)), fr};
    endcase
  endfunction

  task automatic compare();
    logic [VW-1:0] s, p;
    logic [7:0] im;
    logic [1:0] rc, md;
    logic [LANES-1:0] mk;
    logic zf, fexp;
    logic [32:0] rl;
    logic [31:0] el, sl;
    string tag;
    if (q_src.size() == 0) begin
      check(1'b0, "R10 unexpected output", 64'(out_valid), 64'd0);
      return;
    end
    s = q_src.pop_front(); p = q_prev.pop_front(); im = q_imm.pop_front();
    rc = q_rc.pop_front(); mk = q_mask.pop_front(); zf = q_zf.pop_front();
    md = im[2] ? rc : im[1:0]; // R2
    fexp = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      sl = s[32*i +: 32];
      rl = ref_lane(sl, int'(im[7:4]), md);
      if (!mk[i]) begin
        el = zf ? 32'd0 : p[32*i +: 32];
        tag = "R9 R12";
      end else begin
        el = rl[31:0];
        fexp = fexp | rl[32];
        if (sl[30:23] == 8'hFF) tag = (sl[22:0] != 0) ? "R6" : "R7";
        else if (sl[30:0] == 31'd0) tag = "R7";
        else if (sl[30:23] == 8'd0) tag = "R8";
        else if (el[30:0] == 31'd0) tag = "R3";
        else if (im[2]) tag = "R2";
        else tag = "R1";
      end
      check(dst[32*i +: 32] === el, tag, 64'(dst[32*i +: 32]), 64'(el));
    end
    if (im[3]) check(inexact === 1'b0, "R5", 64'(inexact), 64'd0);
    else check(inexact === fexp, "R4", 64'(inexact), 64'(fexp));
  endtask

  bit stall_prev = 1'b0;
  logic [VW-1:0] held;
  logic held_f;
  int sweep = 0;

  task automatic monitor();
    if (stall_prev)
      check(out_valid === 1'b1 && dst === held && inexact === held_f, "R10 hold", 64'(dst[31:0]), 64'(held[31:0]));
    stall_prev = out_valid && !out_ready;
    held = dst;
    held_f = inexact;
    check(in_ready === (!out_valid || out_ready), "R10 ready", 64'(in_ready), 64'(!out_valid || out_ready));
    if (out_valid && out_ready) compare();
    if (in_valid && in_ready) begin
      q_src.push_back(src); q_prev.push_back(prev_dst); q_imm.push_back(ctrl_imm);
      q_rc.push_back(rc_in); q_mask.push_back(wmask); q_zf.push_back(zero_fill);
      sweep++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; src = '0; prev_dst = '0;
    ctrl_imm = '0; rc_in = '0; wmask = '0; zero_fill = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R11 valid", 64'(out_valid), 64'd0);
    check(dst === '0, "R11 dst", 64'(dst[31:0]), 64'd0);
    check(inexact === 1'b0, "R11 flag", 64'(inexact), 64'd0);
    check($bits(dst) == 32 * LANES, "R12 width", 64'($bits(dst)), 64'(32 * LANES));
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      @(negedge clk);
      in_valid  = ($urandom_range(0, 9) < 7);
      out_ready = ($urandom_range(0, 3) != 0);
      for (int i = 0; i < LANES; i++) begin
        src[32*i +: 32] = gen_lane();
        prev_dst[32*i +: 32] = $urandom;
      end
      wmask = ($urandom_range(0, 3) == 0) ? '1 : LANES'($urandom);
      zero_fill = 1'($urandom_range(0, 1));
      rc_in = 2'($urandom);
      if (sweep < 128) ctrl_imm = {4'(sweep), 1'b0, 1'(sweep >> 4), 2'(sweep >> 5)};
      else ctrl_imm = 8'($urandom);
      #1;
      monitor();
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    for (int cyc = 0; cyc < 8; cyc++) begin
      #1;
      monitor();
      @(negedge clk);
    end
    check(q_src.size() == 0 && out_valid === 1'b0, "R10 drained", 64'(q_src.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule